// File: doc/BRIEF.md
# Serial-Addressed SAR Conversion Sequencer

This block is the digital controller of an 8-bit successive-approximation converter that is driven over a serial link. The host pulls the active-low select low and sends a framed channel address on the data input, one bit per rising clock. A start bit marks the frame. The block then picks a positive and a negative analog input for the multiplexer and drives a 0 for one settling clock. After that it runs the binary search against a ladder DAC. Each bit is put on the serial output as soon as the comparator decides it.

When the search ends, the stored result can be sent again with the least significant bit first. An order-control input holds bit 0 on the line for as long as it is high. In the 4-input build the replay starts without waiting for that input. Raising the select at any time clears the block and releases both tristate outputs. The analog multiplexer, the ladder and the comparator sit outside this block.

Top module: `sar_seq_top`

## Requirements
- R1: When `cs_n` is sampled high on a clock edge, or reset is asserted, every register is cleared. From the next cycle `sdo_en`, `busy_en` and `busy` are 0.
- R2: While the block waits for a frame, 0s sampled on `sdi` are ignored. The first 1 is the start bit. It is followed by the assignment bits, most significant first: diff, odd, sel1, sel0 in the 8-input build. No conversion starts before the last assignment bit is sampled.
- R3: The edge that samples the last assignment bit sets `busy`=1 and `sdo_en`=1 and drives `sdo`=0 for exactly one clock, which is the settling slot.
- R4: Single-ended (diff=0): `pos_ch` = 4·sel1 + 2·sel0 + odd, `neg_ref`=1, `neg_ch`=0.
- R5: Differential (diff=1): `pos_ch` = 4·sel1 + 2·sel0 + odd, `neg_ch` = `pos_ch` XOR 1, `neg_ref`=0.
- R6: The bits are tried from bit 7 down to bit 0. While bit k is tried, `dac_code` holds the bits already decided above k, a 1 at bit k, and 0s below. The bit is kept when `cmp_in`=1 (input ≥ ladder). The final code is max(0, min(255, V+ − V−)).
- R7: Bit k of the result appears on `sdo` (8−k) clocks after the settling slot begins. `busy` falls on the same edge that shows bit 0.
- R8: `sdi` is ignored from the edge that latches the address until `cs_n` goes high.
- R9: In the 8-input build, bit 0 stays on `sdo` while `lsb_hold`=1. Each edge that samples `lsb_hold`=0 moves to the next bit, bit 1 up to bit 7, without repeating bit 0.
- R10: After bit 7 of the replay, `sdo` stays driven at 0. No further clock starts a conversion until `cs_n` has gone high and low again.
- R11: In the 4-input build the frame carries three assignment bits: diff, odd, sel. The positive channel is 2·sel + odd; in differential mode the negative channel is the other one of the pair. The replay advances on every edge whatever `lsb_hold` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select; high clears the block |
| sdi | input | 1 | Serial address input |
| lsb_hold | input | 1 | High keeps bit 0 on the line; low lets the replay advance |
| cmp_in | input | 1 | Comparator decision: 1 when the input is at or above the ladder |
| sdo | output | 1 | Serial result output |
| sdo_en | output | 1 | Output enable for `sdo` (0 = high impedance) |
| busy | output | 1 | High while a conversion runs |
| busy_en | output | 1 | Output enable for `busy` |
| pos_ch | output | $clog2(N_CH) | Positive multiplexer input |
| neg_ch | output | $clog2(N_CH) | Negative multiplexer input (differential mode) |
| neg_ref | output | 1 | 1 = the negative input is the common/ground reference |
| dac_code | output | RES | Trial code for the ladder DAC |

## Verification
The assertions check the timing on every cycle. They check the release of the outputs one clock after the select goes high, the low settling slot and the 0x80 first trial. They also check the busy window of exactly eight decision clocks, that the channel code does not move during a conversion, that a differential pair is adjacent, and that no conversion restarts after the result. Only the bench scenarios can show the values themselves. These are the decoded channel for each address, the code produced against the modelled analog inputs (including clamping to 0 and reaching 255), the bit order of both streams, the hold behaviour, and that leading zeros and mid-conversion `sdi` activity change nothing.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial SAR sequencer.
// Assumes: one clock domain, the serial clock.
package sar_seq_pkg;
    // Sequencer phases: wait for frame, binary search, LSB replay, finished.
    typedef enum logic [1:0] {
        ST_LISTEN = 2'd0,
        ST_CONV   = 2'd1,
        ST_TAIL   = 2'd2,
        ST_DONE   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/sar_addr_rx.sv
`timescale 1ns/1ps
// Address frame receiver. It shifts sdi in while the core listens. The frame
// register starts cleared, so leading zeros stay zero and the first 1 acts as
// the start bit. 'hit' fires on the edge that samples the last assignment bit.
// Assumes: clr (select high) is applied before every new frame.
module sar_addr_rx #(
    parameter int N_A = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           listen,
    input  logic           sdi,
    output logic           hit,
    output logic [N_A-1:0] fields_nxt
);
    logic [N_A-1:0] frame_q;

    // Shift the serial input in while the core is listening.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            frame_q <= '0;
        end else if (listen) begin
            frame_q <= {frame_q[N_A-2:0], sdi};
        end
    end

    // The start bit is about to leave the frame register: the frame is complete.
    assign hit        = listen && frame_q[N_A-1];
    assign fields_nxt = {frame_q[N_A-2:0], sdi};
endmodule

// File: rtl/sar_chan_dec.sv
`timescale 1ns/1ps
// Channel decoder. It turns the latched assignment field {diff, odd, sel...}
// into multiplexer selects. The positive index is {sel..., odd}. In
// differential mode the negative input is the other channel of the same
// adjacent pair; otherwise the common/ground reference is negative.
// Assumes: the field is held stable by the core for the whole conversion.
module sar_chan_dec #(
    parameter int N_CH = 8,
    localparam int CH_W = $clog2(N_CH),
    localparam int N_A  = CH_W + 1
) (
    input  logic [N_A-1:0]  fields,
    output logic [CH_W-1:0] pos_ch,
    output logic [CH_W-1:0] neg_ch,
    output logic            neg_ref
);
    logic diff;
    logic odd;

    // Split the field and form both selects.
    always_comb begin
        diff    = fields[N_A-1];
        odd     = fields[N_A-2];
        pos_ch  = {fields[CH_W-2:0], odd};
        neg_ref = !diff;
        neg_ch  = diff ? {fields[CH_W-2:0], !odd} : '0;
    end
endmodule

// File: rtl/sar_core.sv
`timescale 1ns/1ps
// Conversion core: latches the address, runs one settling clock with sdo=0,
// does the RES-step binary search with each decided bit sent at once, and
// replays the result LSB first. The replay waits for lsb_hold=0, or runs on
// its own when AUTO_TAIL is set.
// Assumes: cmp_in is valid one clock after dac_code changes.
module sar_core #(
    parameter int RES       = 8,
    parameter int N_A       = 4,
    parameter bit AUTO_TAIL = 1'b0,
    localparam int IW = $clog2(RES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           hit,
    input  logic [N_A-1:0] fields_nxt,
    input  logic           cmp_in,
    input  logic           lsb_hold,
    output logic           listen,
    output logic [N_A-1:0] fld_q,
    output logic           sdo,
    output logic           sdo_en,
    output logic           busy,
    output logic           busy_en,
    output logic [RES-1:0] dac_code
);
    import sar_seq_pkg::*;

    seq_state_e     state_q;
    logic [RES-1:0] res_q;
    logic [IW-1:0]  idx_q;
    logic [IW-1:0]  idx_up;
    logic           sdo_q, sdo_en_q, busy_q, act_q;
    logic           adv;

    // Pick how the LSB-first replay is paced.
    generate
        if (AUTO_TAIL) begin : g_auto
            logic unused_hold;
            assign unused_hold = lsb_hold;
            assign adv = 1'b1;
        end else begin : g_held
            assign adv = !lsb_hold;
        end
    endgenerate

    assign idx_up = idx_q + IW'(1);

    // Sequencer state, result store and serial output register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state_q  <= ST_LISTEN;
            res_q    <= '0;
            idx_q    <= '0;
            fld_q    <= '0;
            sdo_q    <= 1'b0;
            sdo_en_q <= 1'b0;
            busy_q   <= 1'b0;
            act_q    <= 1'b0;
        end else begin
            act_q <= 1'b1;
            case (state_q)
                ST_LISTEN: begin
                    if (hit) begin
                        fld_q    <= fields_nxt;
                        state_q  <= ST_CONV;
                        busy_q   <= 1'b1;
                        sdo_en_q <= 1'b1;
                        sdo_q    <= 1'b0;
                        res_q    <= '0;
                        idx_q    <= IW'(RES - 1);
                    end
                end
                ST_CONV: begin
                    res_q[idx_q] <= cmp_in;
                    sdo_q        <= cmp_in;
                    if (idx_q == '0) begin
                        state_q <= ST_TAIL;
                        busy_q  <= 1'b0;
                    end else begin
                        idx_q <= idx_q - IW'(1);
                    end
                end
                ST_TAIL: begin
                    if (adv) begin
                        if (idx_q == IW'(RES - 1)) begin
                            state_q <= ST_DONE;
                            sdo_q   <= 1'b0;
                        end else begin
                            idx_q <= idx_up;
                            sdo_q <= res_q[idx_up];
                        end
                    end
                end
                default: begin
                    sdo_q <= 1'b0;
                end
            endcase
        end
    end

    // Trial code: decided upper bits plus the bit under test.
    always_comb begin
        dac_code = '0;
        if (state_q == ST_CONV) begin
            dac_code        = res_q;
            dac_code[idx_q] = 1'b1;
        end
    end

    assign listen  = (state_q == ST_LISTEN);
    assign sdo     = sdo_q;
    assign sdo_en  = sdo_en_q;
    assign busy    = busy_q;
    assign busy_en = act_q;
endmodule

// File: rtl/sar_seq_top.sv
`timescale 1ns/1ps
// Top of the serial SAR sequencer: frame receiver, conversion core, channel
// decoder. N_CH selects the 8-input build (four assignment bits, replay
// paced by lsb_hold) or the 4-input build (three bits, replay runs on its own).
// Assumes: cs_n, sdi and lsb_hold are synchronous to clk.
module sar_seq_top #(
    parameter int N_CH = 8,
    parameter int RES  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    sdi,
    input  logic                    lsb_hold,
    input  logic                    cmp_in,
    output logic                    sdo,
    output logic                    sdo_en,
    output logic                    busy,
    output logic                    busy_en,
    output logic [$clog2(N_CH)-1:0] pos_ch,
    output logic [$clog2(N_CH)-1:0] neg_ch,
    output logic                    neg_ref,
    output logic [RES-1:0]          dac_code
);
    localparam int  CH_W = $clog2(N_CH);
    localparam int  N_A  = CH_W + 1;
    localparam bit  AUTO = (N_CH == 4);

    logic           listen;
    logic           hit;
    logic [N_A-1:0] fields_nxt;
    logic [N_A-1:0] fld_q;

    sar_addr_rx #(.N_A(N_A)) rx_i (
        .clk(clk), .rst_n(rst_n), .clr(cs_n), .listen(listen), .sdi(sdi),
        .hit(hit), .fields_nxt(fields_nxt)
    );

    sar_core #(.RES(RES), .N_A(N_A), .AUTO_TAIL(AUTO)) core_i (
        .clk(clk), .rst_n(rst_n), .clr(cs_n), .hit(hit),
        .fields_nxt(fields_nxt), .cmp_in(cmp_in), .lsb_hold(lsb_hold),
        .listen(listen), .fld_q(fld_q), .sdo(sdo), .sdo_en(sdo_en),
        .busy(busy), .busy_en(busy_en), .dac_code(dac_code)
    );

    sar_chan_dec #(.N_CH(N_CH)) dec_i (
        .fields(fld_q), .pos_ch(pos_ch), .neg_ch(neg_ch), .neg_ref(neg_ref)
    );
endmodule

// File: rtl/sar_seq_chk.sv
`timescale 1ns/1ps
// Checker bound to every sar_seq_top instance: cycle-level timing rules.
module sar_seq_chk #(
    parameter int N_CH = 8,
    parameter int RES  = 8,
    localparam int CH_W = $clog2(N_CH),
    localparam int CW   = $clog2(RES) + 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_n,
    input logic            sdo,
    input logic            sdo_en,
    input logic            busy,
    input logic            busy_en,
    input logic [CH_W-1:0] pos_ch,
    input logic [CH_W-1:0] neg_ch,
    input logic            neg_ref,
    input logic [RES-1:0]  dac_code
);
    logic [CW-1:0] busy_cnt;

    // Count the sampled cycles that busy has been high.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_cnt <= '0;
        else                 busy_cnt <= busy_cnt + CW'(1);
    end

    p_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!sdo_en && !busy_en && !busy));
    p_settle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (sdo_en && !sdo));
    p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && neg_ref) |-> (neg_ch == '0));
    p_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !neg_ref) |-> ((neg_ch ^ pos_ch) == CH_W'(1)));
    p_first_trial_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (dac_code == RES'(1) << (RES - 1)));
    p_trial_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (dac_code != '0));
    p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(cs_n)) |-> (busy_cnt == CW'(RES)));
    p_chan_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(pos_ch) && $stable(neg_ch) && $stable(neg_ref)));
    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_en && !busy) |=> !busy);
endmodule

bind sar_seq_top sar_seq_chk #(.N_CH(N_CH), .RES(RES)) chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo), .sdo_en(sdo_en),
    .busy(busy), .busy_en(busy_en), .pos_ch(pos_ch), .neg_ch(neg_ch),
    .neg_ref(neg_ref), .dac_code(dac_code)
);

// File: tb/sar_seq_top_tb_top.sv
`timescale 1ns/1ps
// Bench: one 8-input and one 4-input sequencer, an analog model, a vector walk.
module sar_seq_top_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, cs8_n = 1'b0, cs4_n = 1'b1, sdi = 1'b0, lsb_hold = 1'b1;
    logic cmp8, cmp4;
    logic sdo8, sdo_en8, busy8, busy_en8, ref8;
    logic [2:0] pos8, neg8;
    logic [7:0] dac8;
    logic sdo4, sdo_en4, busy4, busy_en4, ref4;
    logic [1:0] pos4, neg4;
    logic [7:0] dac4;

    sar_seq_top #(.N_CH(8), .RES(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs8_n), .sdi(sdi), .lsb_hold(lsb_hold),
        .cmp_in(cmp8), .sdo(sdo8), .sdo_en(sdo_en8), .busy(busy8),
        .busy_en(busy_en8), .pos_ch(pos8), .neg_ch(neg8), .neg_ref(ref8),
        .dac_code(dac8));
    sar_seq_top #(.N_CH(4), .RES(8)) dut4_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs4_n), .sdi(sdi), .lsb_hold(lsb_hold),
        .cmp_in(cmp4), .sdo(sdo4), .sdo_en(sdo_en4), .busy(busy4),
        .busy_en(busy_en4), .pos_ch(pos4), .neg_ch(neg4), .neg_ref(ref4),
        .dac_code(dac4));

    // Analog model: channel levels in LSB units; common terminal at 20.
    int vch [8] = '{200, 37, 255, 0, 128, 127, 90, 91};
    localparam int VCOM = 20;
    always_comb begin
        cmp8 = (vch[pos8] - (ref8 ? VCOM : vch[neg8])) >= int'(dac8);
        cmp4 = (vch[{1'b0, pos4}] - (ref4 ? 0 : vch[{1'b0, neg4}])) >= int'(dac4);
    end

    bit sel4 = 1'b0;
    logic o_sdo, o_en, o_busy, o_ben, o_ref;
    logic [2:0] o_pos, o_neg;
    logic [7:0] o_dac;
    assign o_sdo  = sel4 ? sdo4 : sdo8;
    assign o_en   = sel4 ? sdo_en4 : sdo_en8;
    assign o_busy = sel4 ? busy4 : busy8;
    assign o_ben  = sel4 ? busy_en4 : busy_en8;
    assign o_ref  = sel4 ? ref4 : ref8;
    assign o_pos  = sel4 ? {1'b0, pos4} : pos8;
    assign o_neg  = sel4 ? {1'b0, neg4} : neg8;
    assign o_dac  = sel4 ? dac4 : dac8;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Vector: {addr[3:0], leading zeros[1:0], hold cycles[1:0]}.
    localparam logic [7:0] VEC [10] = '{
        8'b0000_00_01, 8'b0001_01_00, 8'b0111_10_11, 8'b0100_11_10,
        8'b0101_00_01, 8'b1000_01_10, 8'b1100_10_00, 8'b1110_00_11,
        8'b1010_11_01, 8'b1111_01_00};

    task automatic run_conv(input bit is4, input logic [3:0] a, input int lead,
                            input int hold_cyc);
        int nb, p, n, r, vp, vn, ec;
        bit d, o;
        logic [7:0] code;
        nb = is4 ? 3 : 4;
        d  = a[nb-1];
        o  = a[nb-2];
        p  = is4 ? int'({a[0], o}) : int'({a[1], a[0], o});
        n  = d ? (p ^ 1) : 0;
        vp = vch[p];
        vn = d ? vch[n] : (is4 ? 0 : VCOM);
        ec = vp - vn;
        if (ec < 0) ec = 0;
        if (ec > 255) ec = 255;
        code = 8'(ec);
        sel4 = is4; lsb_hold = 1'b1; sdi = 1'b0;
        if (is4) cs4_n = 1'b0; else cs8_n = 1'b0;
        repeat (lead + 1) @(negedge clk);
        check("R2 leading zeros keep busy low", int'(o_busy), 0);
        sdi = 1'b1;
        @(negedge clk);
        for (int i = nb - 1; i >= 0; i--) begin
            if (i == 0) check("R2 no start before last bit", int'(o_busy), 0);
            sdi = a[i];
            @(negedge clk);
        end
        check("R3 busy at latch", int'(o_busy), 1);
        check("R3 settle slot drives 0", int'({o_en, o_sdo}), 2);
        check(d ? "R5 positive channel" : "R4 positive channel", int'(o_pos), p);
        check(is4 ? "R11 negative channel" : (d ? "R5 negative channel" : "R4 negative channel"),
              int'({o_ref, o_neg}), d ? n : 8);
        for (int k = 7; k >= 0; k--) begin
            r = int'(code & ~((9'd1 << (k + 1)) - 9'd1) & 8'hFF) | (1 << k);
            check("R6 trial code", int'(o_dac), r);
            sdi = ~sdi;
            @(negedge clk);
            check(is4 ? "R11 R7 MSB-first bit" : "R7 MSB-first bit", int'(o_sdo), int'(code[k]));
            check("R7 busy window", int'(o_busy), (k != 0) ? 1 : 0);
        end
        sdi = 1'b1;
        if (!is4) begin
            for (int h = 0; h < hold_cyc; h++) begin
                @(negedge clk);
                check("R9 LSB held", int'(o_sdo), int'(code[0]));
            end
            lsb_hold = 1'b0;
        end
        for (int k = 1; k < 8; k++) begin
            @(negedge clk);
            check(is4 ? "R11 auto LSB-first bit" : "R9 LSB-first bit", int'(o_sdo), int'(code[k]));
        end
        for (int t = 0; t < 3; t++) begin
            @(negedge clk);
            check("R10 drives 0 after stream", int'({o_en, o_sdo, o_busy}), 4);
        end
        check("R8 result unaffected by sdi", int'(code), ec);
        if (is4) cs4_n = 1'b1; else cs8_n = 1'b1;
        sdi = 1'b0; lsb_hold = 1'b1;
        @(negedge clk);
        check("R1 outputs released", int'({o_en, o_ben, o_busy}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset clears sdo_en", int'(sdo_en8), 0);
        check("R1 reset clears busy_en", int'(busy_en8), 0);
        cs8_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        for (int v = 0; v < 10; v++)
            run_conv(1'b0, VEC[v][7:4], int'(VEC[v][3:2]), int'(VEC[v][1:0]));
        // R1: abort in the middle of a conversion, then a clean restart.
        cs8_n = 1'b0; sdi = 1'b1;
        repeat (8) @(negedge clk);
        check("R1 abort mid-conversion busy was high", int'(busy8), 1);
        cs8_n = 1'b1;
        @(negedge clk);
        check("R1 abort releases outputs", int'({sdo_en8, busy_en8, busy8}), 0);
        sdi = 1'b0;
        run_conv(1'b0, 4'b0000, 0, 1);
        // R11: 4-input build, three assignment bits, self-paced replay.
        run_conv(1'b1, 4'b0001, 0, 0);
        run_conv(1'b1, 4'b0101, 1, 0);
        run_conv(1'b1, 4'b0110, 2, 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule